// File: doc/BRIEF.md
# Flash Completion Polling Controller

This engine runs on the host side of a parallel NOR flash. It decides when a program or erase that software has already started inside the flash has finished. Software pulses a start with four items: the data word it expects the flash to hold at the end, the address to poll, whether the operation was a write-buffer program, and an upper bound on the number of status reads. The controller then issues status reads through a request/valid handshake. It judges each returned word by one of two algorithms, chosen at start. It reports a single outcome: pass, fail or buffer-abort.

The controller is a single state machine. Its states are:

- `S_IDLE`: waiting for a start.
- `S_FIRST`: the first read in toggle mode, which only records the toggle bit.
- `S_POLL`: the main polling loop.
- `S_RECHK`: the confirming re-read in data mode.
- `S_CONF_A` and `S_CONF_B`: the two confirming reads in toggle mode.
- `S_DONE`: the one-cycle report.

Its transitions are:

- start: `S_IDLE` to `S_FIRST` in toggle mode, or `S_IDLE` to `S_POLL` in data mode.
- first read taken: `S_FIRST` to `S_POLL`.
- continue polling: `S_POLL` to `S_POLL`.
- flag seen: `S_POLL` to `S_RECHK` or to `S_CONF_A`.
- confirm: `S_CONF_A` to `S_CONF_B`.
- verdict: any read state to `S_DONE`.
- retire: `S_DONE` to `S_IDLE`.

A small read-budget counter and a combinational status decoder sit under the state machine.

Top module: `nor_done_poller`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `rd_req_o` are low and `result_o` is 2'b00.
- R2: A start taken in idle latches its inputs. From the next cycle, `rd_req_o` is high with `rd_addr_o` equal to the latched `addr_i`. A read completes in a cycle where both `rd_req_o` and `rd_valid_i` are high, and `rd_req_o` stays high until that cycle.
- R3: With `mode_i`=0 (data polling), a read whose bit 7 equals bit 7 of the expected word ends the poll with result 2'b01 (pass).
- R4: In data polling, a read with a bit 7 mismatch and bit 5 = 1 causes exactly one more read. If that re-read matches on bit 7, the result is pass; otherwise it is 2'b10 (fail).
- R5: With `mode_i`=1 (toggle polling), the first read only records bit 6. Any later main read whose bit 6 equals that of the read before it ends with pass.
- R6: In toggle polling, a main read whose bit 6 still differs and whose bit 5 is 1 causes two further reads. If bit 6 is equal across those two reads, the result is pass; otherwise it is fail.
- R7: When `buf_prog_i` was high at start, a read with bit 1 = 1 triggers the same confirming reads as bit 5. A confirmation that fails with bit 1 = 1 on its last read reports 2'b11 (abort) instead of fail. With `buf_prog_i` low, bit 1 has no effect.
- R8: The main-loop reads are counted, and the confirming reads are not. An inconclusive main read that brings the count to `max_polls_i` reports fail; a limit of 0 acts as 1. A flagged read at the limit still gets its confirming reads.
- R9: The outcome appears as `done_o` high for exactly one cycle with a nonzero `result_o`. `result_o` is 2'b00 whenever `done_o` is low, and the controller is idle in the following cycle.
- R10: A start request while `busy_o` is high, including the done cycle, is ignored: address, mode and outcome are unaffected and no new poll begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a poll (taken only when idle) |
| mode_i | input | 1 | 0 = data polling, 1 = toggle polling |
| exp_data_i | input | DW | Word expected at the end of the operation |
| addr_i | input | AW | Address to poll |
| buf_prog_i | input | 1 | Operation is a write-buffer program |
| max_polls_i | input | CW | Main-loop read limit |
| rd_req_o | output | 1 | Status read request |
| rd_addr_o | output | AW | Status read address |
| rd_valid_i | input | 1 | Read data valid, completes the request |
| rd_data_i | input | DW | Status word from the flash |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 01 pass, 10 fail, 11 abort, 00 none |

## Verification
Two functions can fall in the same cycle: the read budget running out, and the flag-driven confirmation. This happens when the read that reaches the poll limit also shows bit 5. The bench provokes it with a limit of one and a first read carrying bit 5, then a matching re-read, and expects pass after two reads rather than an early fail. A start pulse held during polling and another placed exactly on the done cycle are judged from the address output, the outcome code and the idle state that follow.

// File: rtl/nor_poll_pkg.sv
package nor_poll_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FIRST,
        S_POLL,
        S_RECHK,
        S_CONF_A,
        S_CONF_B,
        S_DONE
    } poll_state_e;

    typedef enum logic [1:0] {
        RES_NONE  = 2'b00,
        RES_PASS  = 2'b01,
        RES_FAIL  = 2'b10,
        RES_ABORT = 2'b11
    } poll_res_e;

    localparam int POL_BIT = 7;
    localparam int TOG_BIT = 6;
    localparam int TMO_BIT = 5;
    localparam int ABT_BIT = 1;

endpackage

// File: rtl/poll_status_eval.sv
module poll_status_eval
    import nor_poll_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] data_i,
    input  logic [DW-1:0] exp_i,
    input  logic          prev_tog_i,
    input  logic          buf_i,
    output logic          match_o,
    output logic          steady_o,
    output logic          tog_o,
    output logic          flag_o,
    output logic          abt_o
);
    logic unused_bits;
    assign unused_bits = ^{data_i, exp_i};

    always_comb begin
        match_o  = (data_i[POL_BIT] == exp_i[POL_BIT]);
        tog_o    = data_i[TOG_BIT];
        steady_o = (data_i[TOG_BIT] == prev_tog_i);
        abt_o    = buf_i & data_i[ABT_BIT];
        flag_o   = data_i[TMO_BIT] | abt_o;
    end
endmodule

// File: rtl/poll_budget.sv
module poll_budget #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          inc_i,
    input  logic [CW-1:0] limit_i,
    output logic          last_o
);
    localparam int XW = CW + 1;

    logic [CW-1:0] cnt_q;
    logic [XW-1:0] cnt_next;

    assign cnt_next = {1'b0, cnt_q} + XW'(1);
    assign last_o   = (cnt_next >= {1'b0, limit_i});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clear_i) cnt_q <= '0;
        else if (inc_i)   cnt_q <= cnt_next[CW-1:0];
    end

    // R8: the budget never wraps; the limit ends the loop first
    p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |-> (cnt_q != '1));
endmodule

// File: rtl/nor_done_poller.sv
module nor_done_poller
    import nor_poll_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 23,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          mode_i,
    input  logic [DW-1:0] exp_data_i,
    input  logic [AW-1:0] addr_i,
    input  logic          buf_prog_i,
    input  logic [CW-1:0] max_polls_i,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_valid_i,
    input  logic [DW-1:0] rd_data_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [1:0]    result_o
);
    poll_state_e   state_q, state_d;
    poll_res_e     res_q, res_d;
    logic          mode_q, buf_q, prev_q, prev_d;
    logic [DW-1:0] exp_q;
    logic [AW-1:0] addr_q;
    logic [CW-1:0] lim_q;
    logic          accept, cnt_clr, cnt_inc, cnt_last;
    logic          match, steady, tog, flag, abt;

    assign accept = rd_req_o & rd_valid_i;

    poll_status_eval #(.DW(DW)) u_eval (
        .data_i     (rd_data_i),
        .exp_i      (exp_q),
        .prev_tog_i (prev_q),
        .buf_i      (buf_q),
        .match_o    (match),
        .steady_o   (steady),
        .tog_o      (tog),
        .flag_o     (flag),
        .abt_o      (abt)
    );

    poll_budget #(.CW(CW)) u_budget (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (cnt_clr),
        .inc_i   (cnt_inc),
        .limit_i (lim_q),
        .last_o  (cnt_last)
    );

    // next state and verdict
    always_comb begin
        state_d = state_q;
        res_d   = res_q;
        prev_d  = prev_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    state_d = mode_i ? S_FIRST : S_POLL;
                    res_d   = RES_NONE;
                    cnt_clr = 1'b1;
                end
            end
            S_FIRST: begin
                if (accept) begin
                    cnt_inc = 1'b1;
                    prev_d  = tog;
                    if (cnt_last) begin
                        state_d = S_DONE;
                        res_d   = RES_FAIL;
                    end else begin
                        state_d = S_POLL;
                    end
                end
            end
            S_POLL: begin
                if (accept) begin
                    if (!mode_q && match) begin
                        state_d = S_DONE;
                        res_d   = RES_PASS;
                    end else if (mode_q && steady) begin
                        state_d = S_DONE;
                        res_d   = RES_PASS;
                    end else if (flag) begin
                        state_d = mode_q ? S_CONF_A : S_RECHK;
                    end else begin
                        cnt_inc = 1'b1;
                        prev_d  = tog;
                        if (cnt_last) begin
                            state_d = S_DONE;
                            res_d   = RES_FAIL;
                        end
                    end
                end
            end
            S_RECHK: begin
                if (accept) begin
                    state_d = S_DONE;
                    res_d   = match ? RES_PASS : (abt ? RES_ABORT : RES_FAIL);
                end
            end
            S_CONF_A: begin
                if (accept) begin
                    prev_d  = tog;
                    state_d = S_CONF_B;
                end
            end
            S_CONF_B: begin
                if (accept) begin
                    state_d = S_DONE;
                    res_d   = steady ? RES_PASS : (abt ? RES_ABORT : RES_FAIL);
                end
            end
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register with the values latched at start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            res_q   <= RES_NONE;
            prev_q  <= 1'b0;
            mode_q  <= 1'b0;
            buf_q   <= 1'b0;
            exp_q   <= '0;
            addr_q  <= '0;
            lim_q   <= '0;
        end else begin
            state_q <= state_d;
            res_q   <= res_d;
            prev_q  <= prev_d;
            if (state_q == S_IDLE && start_i) begin
                mode_q <= mode_i;
                buf_q  <= buf_prog_i;
                exp_q  <= exp_data_i;
                addr_q <= addr_i;
                lim_q  <= max_polls_i;
            end
        end
    end

    // outputs
    always_comb begin
        rd_req_o  = (state_q == S_FIRST) || (state_q == S_POLL) ||
                    (state_q == S_RECHK) || (state_q == S_CONF_A) ||
                    (state_q == S_CONF_B);
        rd_addr_o = addr_q;
        busy_o    = (state_q != S_IDLE);
        done_o    = (state_q == S_DONE);
        result_o  = done_o ? res_q : RES_NONE;
    end

    // R9: done is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: a done pulse always carries an outcome
    p_done_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (result_o != RES_NONE));

    // R10: the polled address cannot change during a poll
    p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(rd_addr_o));

    // R4: a flagged data-mode mismatch is followed by another read, not a verdict
    p_recheck_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_POLL && accept && !mode_q && !match && flag)
            |=> (rd_req_o && !done_o));
endmodule

// File: tb/nor_done_poller_bench.sv
module nor_done_poller_bench;
    localparam int DW = 16;
    localparam int AW = 23;
    localparam int CW = 8;

    typedef struct packed {
        logic             mode;
        logic [15:0]      expd;
        logic             bufp;
        logic [7:0]       maxp;
        logic             lat;
        logic [3:0][15:0] words;   // words[0] is returned first
        logic [1:0]       res;
        logic [3:0]       nrd;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        // R3 data pass on third read
        '{1'b0, 16'h0080, 1'b0, 8'd10, 1'b0, {16'h0000,16'h0080,16'h0000,16'h0000}, 2'b01, 4'd3},
        // R4 bit5 then matching re-read, with wait states
        '{1'b0, 16'h0080, 1'b0, 8'd10, 1'b1, {16'h0000,16'h0000,16'h0080,16'h0020}, 2'b01, 4'd2},
        // R4 bit5 then mismatch re-read
        '{1'b0, 16'h0080, 1'b0, 8'd10, 1'b0, {16'h0000,16'h0000,16'h0020,16'h0020}, 2'b10, 4'd2},
        // R7 buffer program, bit1 twice -> abort
        '{1'b0, 16'h0080, 1'b1, 8'd10, 1'b0, {16'h0000,16'h0000,16'h0002,16'h0002}, 2'b11, 4'd2},
        // R7 bit1 without buffer program has no effect
        '{1'b0, 16'h0080, 1'b0, 8'd10, 1'b0, {16'h0000,16'h0080,16'h0000,16'h0002}, 2'b01, 4'd3},
        // R8 limit of 3 reached
        '{1'b0, 16'h0080, 1'b0, 8'd3,  1'b0, {16'h0000,16'h0000,16'h0000,16'h0000}, 2'b10, 4'd3},
        // R5 toggle stops on third read
        '{1'b1, 16'h0000, 1'b0, 8'd10, 1'b0, {16'h0000,16'h0000,16'h0000,16'h0040}, 2'b01, 4'd3},
        // R6 toggling with bit5, confirm reads steady -> pass, wait states
        '{1'b1, 16'h0000, 1'b0, 8'd10, 1'b1, {16'h0040,16'h0040,16'h0020,16'h0040}, 2'b01, 4'd4},
        // R6 confirm reads still toggling -> fail
        '{1'b1, 16'h0000, 1'b0, 8'd10, 1'b0, {16'h0000,16'h0040,16'h0020,16'h0040}, 2'b10, 4'd4},
        // R7 toggle buffer program, bit1 on last toggling read -> abort
        '{1'b1, 16'h0000, 1'b1, 8'd10, 1'b0, {16'h0042,16'h0002,16'h0042,16'h0000}, 2'b11, 4'd4},
        // R8 toggle limit of 2
        '{1'b1, 16'h0000, 1'b0, 8'd2,  1'b0, {16'h0000,16'h0000,16'h0040,16'h0000}, 2'b10, 4'd2},
        // R3 expected bit 0
        '{1'b0, 16'h0000, 1'b0, 8'd10, 1'b0, {16'h0000,16'h0000,16'h0000,16'h0080}, 2'b01, 4'd2},
        // R8 flagged read at the limit still rechecks
        '{1'b0, 16'h0080, 1'b0, 8'd1,  1'b0, {16'h0000,16'h0000,16'h0080,16'h0020}, 2'b01, 4'd2},
        // R8 limit 0 acts as 1
        '{1'b0, 16'h0080, 1'b0, 8'd0,  1'b0, {16'h0000,16'h0000,16'h0000,16'h0000}, 2'b10, 4'd1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0, mode_i = 1'b0, buf_prog_i = 1'b0;
    logic [DW-1:0] exp_data_i = '0;
    logic [AW-1:0] addr_i = '0;
    logic [CW-1:0] max_polls_i = '0;
    logic          rd_valid_i = 1'b0;
    logic [DW-1:0] rd_data_i = '0;
    logic          rd_req_o, busy_o, done_o;
    logic [AW-1:0] rd_addr_o;
    logic [1:0]    result_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    nor_done_poller #(.DW(DW), .AW(AW), .CW(CW)) u_nor_done_poller (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .exp_data_i(exp_data_i), .addr_i(addr_i), .buf_prog_i(buf_prog_i),
        .max_polls_i(max_polls_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i), .busy_o(busy_o),
        .done_o(done_o), .result_o(result_o)
    );

    task automatic chk(input logic ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic run_vec(input int vi);
        vec_t v = VECS[vi];
        int   rd = 0;
        bit   ph = 1'b0;
        bit   seen = 1'b0;
        logic [AW-1:0] a = AW'(32'h100 + vi);
        @(negedge clk);
        mode_i = v.mode; exp_data_i = v.expd; buf_prog_i = v.bufp;
        max_polls_i = v.maxp; addr_i = a; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(rd_req_o && rd_addr_o == a, "R2", int'(rd_addr_o), int'(a));
        for (int c = 0; c < 40 && !seen; c++) begin
            if (done_o) begin
                seen = 1'b1;
                rd_valid_i = 1'b0;
                chk(result_o == v.res, "R3-R8 outcome", int'(result_o), int'(v.res));
                chk(rd == int'(v.nrd), "R4/R6/R8 read count", rd, int'(v.nrd));
            end else begin
                if (rd_req_o && !(v.lat && !ph)) begin
                    rd_valid_i = 1'b1;
                    rd_data_i  = (rd < 4) ? v.words[rd] : 16'h0000;
                    rd++;
                    ph = 1'b0;
                end else begin
                    rd_valid_i = 1'b0;
                    ph = 1'b1;
                end
                @(negedge clk);
            end
        end
        chk(seen, "R9 done seen", int'(seen), 1);
        @(negedge clk);
        chk(!done_o && !busy_o && result_o == 2'b00, "R9 one-cycle pulse", int'(done_o), 0);
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy_o && !done_o && !rd_req_o && result_o == 2'b00, "R1", int'(busy_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !rd_req_o, "R1 after release", int'(rd_req_o), 0);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R10: start while polling is ignored
        @(negedge clk);
        mode_i = 1'b0; exp_data_i = 16'h0080; buf_prog_i = 1'b0;
        max_polls_i = 8'd10; addr_i = 23'h123; start_i = 1'b1;
        @(negedge clk);
        rd_valid_i = 1'b0;
        mode_i = 1'b1; addr_i = 23'h456;
        @(negedge clk);
        start_i = 1'b0;
        chk(rd_addr_o == 23'h123, "R10 address kept", int'(rd_addr_o), 'h123);
        rd_valid_i = 1'b1; rd_data_i = 16'h0080;
        @(negedge clk);
        rd_valid_i = 1'b0;
        chk(done_o && result_o == 2'b01, "R10 data mode kept", int'(result_o), 1);
        // R10: start during the done cycle is ignored
        start_i = 1'b1; addr_i = 23'h077;
        @(negedge clk);
        start_i = 1'b0;
        chk(!busy_o && !rd_req_o, "R10 start on done cycle", int'(busy_o), 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule